// File: doc/BRIEF.md
# Pipelined Signed Complex Multiplier

This block multiplies two signed complex operands, a = a_re + j·a_im and b = b_re + j·b_im. A build-time option chooses between the plain product a·b and the product with the conjugate of b, a·conj(b). All operands and results are two's complement. The full result width is the sum of the operand widths plus one bit. At that width the add or subtract after the partial products can never overflow. A parameter sets the width actually delivered at the outputs.

The datapath has four register groups: after the inputs, after the four partial products, after the add/subtract, and after the output resize. Each group has its own depth parameter, and any depth may be zero. A single clock enable advances every register. The input valid never touches the arithmetic. It travels through the same registers as the data and leaves as the output valid, so it stays aligned with its result. A synchronous reset clears every register.

Top module: `cplx_mult_pipe`

## Requirements
- R1: With CONJ_B = 0 the real output is a_re·b_re − a_im·b_im and the imaginary output is a_re·b_im + a_im·b_re.
- R2: With CONJ_B = 1 the real output is a_re·b_re + a_im·b_im and the imaginary output is a_im·b_re − a_re·b_im.
- R3: A result appears at the outputs exactly DEPTH_IN + DEPTH_PROD + DEPTH_ADD + DEPTH_OUT enabled clock edges after its operands are sampled. A stage of depth zero adds no register, and with all four depths at zero the outputs follow the inputs combinationally.
- R4: out_vld reproduces in_vld with the same latency as the data. in_vld has no effect on p_re or p_im.
- R5: At OUT_W = A_W + B_W + 1 every result is exact. This includes the corner cases: all four operands at the most positive value, all at the most negative value, and mixes of most-positive with most-negative or negated most-positive values.
- R6: When OUT_W is below the full width, the outputs carry the OUT_W least significant bits of the exact result (two's-complement wrap). When OUT_W is above the full width, the outputs are the sign-extended exact result.
- R7: While ce is low, no register changes, so the registered outputs and out_vld hold their values.
- R8: Reset takes priority over ce and clears every register. In a configuration with at least one register, the edge after reset is sampled shows p_re = 0, p_im = 0 and out_vld = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for every pipeline register |
| a_re | input | A_W | Real part of operand a, signed |
| a_im | input | A_W | Imaginary part of operand a, signed |
| b_re | input | B_W | Real part of operand b, signed |
| b_im | input | B_W | Imaginary part of operand b, signed |
| in_vld | input | 1 | Input qualifier, only delayed |
| p_re | output | OUT_W | Real part of the product, signed |
| p_im | output | OUT_W | Imaginary part of the product, signed |
| out_vld | output | 1 | in_vld delayed by the total latency |

## Verification
The bench builds four copies of the block, each with 4-bit operands:

- u_dut: plain product, natural 9-bit output, depths 1/0/1/1.
- u_conj: conjugated product, 9-bit output, depths 0/2/1/0.
- u_comb: plain product, all depths zero, 6-bit output. Being fully combinational with a narrow output, it exercises wrapping.
- u_wide: conjugated product, 12-bit output, depths 2/1/0/1. It exercises sign extension together with a deeper input stage.

Taken together, these copies reach both product modes, both resize directions, the combinational path and unequal depth splits. All four copies see the same directed corner operands, a phase with a randomly gated clock enable, and a sweep of all four operands over −7..+7.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

   // Upper bound accepted for any single register group
   localparam int CMUL_MAX_DEPTH = 16;

   // Total register count between operands and result
   function automatic int cmul_latency(int d_in, int d_prod, int d_add, int d_out);
      return d_in + d_prod + d_add + d_out;
   endfunction

endpackage

// File: rtl/cmul_stage.sv
// Register group of configurable depth; depth zero is a plain wire.
module cmul_stage #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_reg
         logic [W-1:0] sr [DEPTH];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
            end else if (ce) begin
               sr[0] <= d;
               for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
            end
         end

         assign q = sr[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/cmul_products.sv
// The four signed partial products of a complex multiply.
module cmul_products #(
   parameter int A_W = 4,
   parameter int B_W = 4,
   localparam int PROD_W = A_W + B_W
) (
   input  logic signed [A_W-1:0]    op_ar,
   input  logic signed [A_W-1:0]    op_ai,
   input  logic signed [B_W-1:0]    op_br,
   input  logic signed [B_W-1:0]    op_bi,
   output logic signed [PROD_W-1:0] pp_rr,
   output logic signed [PROD_W-1:0] pp_ii,
   output logic signed [PROD_W-1:0] pp_ri,
   output logic signed [PROD_W-1:0] pp_ir
);

   logic signed [PROD_W-1:0] x_ar, x_ai, x_br, x_bi;

   assign x_ar = PROD_W'(op_ar);
   assign x_ai = PROD_W'(op_ai);
   assign x_br = PROD_W'(op_br);
   assign x_bi = PROD_W'(op_bi);

   assign pp_rr = x_ar * x_br;
   assign pp_ii = x_ai * x_bi;
   assign pp_ri = x_ar * x_bi;
   assign pp_ir = x_ai * x_br;

   // a zero first operand must null every partial product
   always_comb begin
      if (op_ar == '0 && op_ai == '0)
         AST_ZERO_A: assert (pp_rr == '0 && pp_ii == '0 && pp_ri == '0 && pp_ir == '0); // R1
   end

endmodule

// File: rtl/cmul_combine.sv
// Adds/subtracts partial products into real and imaginary sums.
module cmul_combine #(
   parameter int PROD_W = 8,
   parameter bit CONJ   = 1'b0,
   localparam int SUM_W = PROD_W + 1
) (
   input  logic signed [PROD_W-1:0] pp_rr,
   input  logic signed [PROD_W-1:0] pp_ii,
   input  logic signed [PROD_W-1:0] pp_ri,
   input  logic signed [PROD_W-1:0] pp_ir,
   output logic signed [SUM_W-1:0]  sum_re,
   output logic signed [SUM_W-1:0]  sum_im
);

   logic signed [SUM_W-1:0] e_rr, e_ii, e_ri, e_ir;

   assign e_rr = SUM_W'(pp_rr);
   assign e_ii = SUM_W'(pp_ii);
   assign e_ri = SUM_W'(pp_ri);
   assign e_ir = SUM_W'(pp_ir);

   generate
      if (CONJ) begin : g_conj
         assign sum_re = e_rr + e_ii;
         assign sum_im = e_ir - e_ri;
      end else begin : g_plain
         assign sum_re = e_rr - e_ii;
         assign sum_im = e_ri + e_ir;
      end
   endgenerate

endmodule

// File: rtl/cmul_resize.sv
// Signed width adaptation: keep low bits when narrowing, sign-extend when widening.
module cmul_resize #(
   parameter int IW = 9,
   parameter int OW = 9
) (
   input  logic signed [IW-1:0] din,
   output logic signed [OW-1:0] dout
);

   generate
      if (OW < IW) begin : g_wrap
         assign dout = din[OW-1:0];
      end else if (OW == IW) begin : g_same
         assign dout = din;
      end else begin : g_sext
         assign dout = {{(OW-IW){din[IW-1]}}, din};
      end
   endgenerate

endmodule

// File: rtl/cplx_mult_pipe.sv
module cplx_mult_pipe
   import cmul_pkg::*;
#(
   parameter int A_W        = 4,
   parameter int B_W        = 4,
   parameter int OUT_W      = 9,
   parameter bit CONJ_B     = 1'b0,
   parameter int DEPTH_IN   = 1,
   parameter int DEPTH_PROD = 0,
   parameter int DEPTH_ADD  = 1,
   parameter int DEPTH_OUT  = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ce,
   input  logic signed [A_W-1:0]   a_re,
   input  logic signed [A_W-1:0]   a_im,
   input  logic signed [B_W-1:0]   b_re,
   input  logic signed [B_W-1:0]   b_im,
   input  logic                    in_vld,
   output logic signed [OUT_W-1:0] p_re,
   output logic signed [OUT_W-1:0] p_im,
   output logic                    out_vld
);

   localparam int PROD_W = A_W + B_W;
   localparam int SUM_W  = PROD_W + 1;
   localparam int LAT    = cmul_latency(DEPTH_IN, DEPTH_PROD, DEPTH_ADD, DEPTH_OUT);
   localparam int W_S1   = 2*A_W + 2*B_W + 1;
   localparam int W_S2   = 4*PROD_W + 1;
   localparam int W_S3   = 2*SUM_W + 1;
   localparam int W_S4   = 2*OUT_W + 1;

   // elaboration-time parameter checks
   generate
      if (A_W < 2 || B_W < 2) begin : g_bad_in_w
         $error("cplx_mult_pipe: operand widths must be at least 2");
      end
      if (OUT_W < 2) begin : g_bad_out_w
         $error("cplx_mult_pipe: OUT_W must be at least 2");
      end
      if (DEPTH_IN < 0 || DEPTH_PROD < 0 || DEPTH_ADD < 0 || DEPTH_OUT < 0) begin : g_bad_neg
         $error("cplx_mult_pipe: stage depths must not be negative");
      end
      if (DEPTH_IN > CMUL_MAX_DEPTH || DEPTH_PROD > CMUL_MAX_DEPTH ||
          DEPTH_ADD > CMUL_MAX_DEPTH || DEPTH_OUT > CMUL_MAX_DEPTH) begin : g_bad_deep
         $error("cplx_mult_pipe: a stage depth exceeds CMUL_MAX_DEPTH");
      end
   endgenerate

   // ---- group 1: operands ----
   logic [W_S1-1:0] s1_d, s1_q;
   logic            s1_vld;
   logic signed [A_W-1:0] s1_ar, s1_ai;
   logic signed [B_W-1:0] s1_br, s1_bi;

   assign s1_d = {in_vld, a_re, a_im, b_re, b_im};

   cmul_stage #(.W(W_S1), .DEPTH(DEPTH_IN)) u_stg_in (
      .clk(clk), .rst(rst), .ce(ce), .d(s1_d), .q(s1_q)
   );

   assign s1_vld = s1_q[W_S1-1];
   assign s1_ar  = s1_q[2*A_W+2*B_W-1 -: A_W];
   assign s1_ai  = s1_q[A_W+2*B_W-1 -: A_W];
   assign s1_br  = s1_q[2*B_W-1 -: B_W];
   assign s1_bi  = s1_q[B_W-1:0];

   // ---- partial products and group 2 ----
   logic signed [PROD_W-1:0] pp_rr, pp_ii, pp_ri, pp_ir;

   cmul_products #(.A_W(A_W), .B_W(B_W)) u_prod (
      .op_ar(s1_ar), .op_ai(s1_ai), .op_br(s1_br), .op_bi(s1_bi),
      .pp_rr(pp_rr), .pp_ii(pp_ii), .pp_ri(pp_ri), .pp_ir(pp_ir)
   );

   logic [W_S2-1:0] s2_d, s2_q;
   logic            s2_vld;
   logic signed [PROD_W-1:0] s2_rr, s2_ii, s2_ri, s2_ir;

   assign s2_d = {s1_vld, pp_rr, pp_ii, pp_ri, pp_ir};

   cmul_stage #(.W(W_S2), .DEPTH(DEPTH_PROD)) u_stg_prod (
      .clk(clk), .rst(rst), .ce(ce), .d(s2_d), .q(s2_q)
   );

   assign s2_vld = s2_q[W_S2-1];
   assign s2_rr  = s2_q[4*PROD_W-1 -: PROD_W];
   assign s2_ii  = s2_q[3*PROD_W-1 -: PROD_W];
   assign s2_ri  = s2_q[2*PROD_W-1 -: PROD_W];
   assign s2_ir  = s2_q[PROD_W-1:0];

   // ---- add/subtract and group 3 ----
   logic signed [SUM_W-1:0] sum_re, sum_im;

   cmul_combine #(.PROD_W(PROD_W), .CONJ(CONJ_B)) u_comb (
      .pp_rr(s2_rr), .pp_ii(s2_ii), .pp_ri(s2_ri), .pp_ir(s2_ir),
      .sum_re(sum_re), .sum_im(sum_im)
   );

   logic [W_S3-1:0] s3_d, s3_q;
   logic            s3_vld;
   logic signed [SUM_W-1:0] s3_re, s3_im;

   assign s3_d = {s2_vld, sum_re, sum_im};

   cmul_stage #(.W(W_S3), .DEPTH(DEPTH_ADD)) u_stg_add (
      .clk(clk), .rst(rst), .ce(ce), .d(s3_d), .q(s3_q)
   );

   assign s3_vld = s3_q[W_S3-1];
   assign s3_re  = s3_q[2*SUM_W-1 -: SUM_W];
   assign s3_im  = s3_q[SUM_W-1:0];

   // ---- resize and group 4 ----
   logic signed [OUT_W-1:0] rz_re, rz_im;

   cmul_resize #(.IW(SUM_W), .OW(OUT_W)) u_rz_re (.din(s3_re), .dout(rz_re));
   cmul_resize #(.IW(SUM_W), .OW(OUT_W)) u_rz_im (.din(s3_im), .dout(rz_im));

   logic [W_S4-1:0] s4_d, s4_q;

   assign s4_d = {s3_vld, rz_re, rz_im};

   cmul_stage #(.W(W_S4), .DEPTH(DEPTH_OUT)) u_stg_out (
      .clk(clk), .rst(rst), .ce(ce), .d(s4_d), .q(s4_q)
   );

   assign out_vld = s4_q[W_S4-1];
   assign p_re    = s4_q[2*OUT_W-1 -: OUT_W];
   assign p_im    = s4_q[OUT_W-1:0];

   // ---- assertions (only meaningful when registers exist) ----
   generate
      if (LAT > 0) begin : g_chk
         localparam int CW = $clog2(LAT + 1) + 1;
         logic [CW-1:0] vcnt;
         logic          rst_d;

         // number of valid tokens currently held in the pipeline
         always_ff @(posedge clk) begin
            if (rst) vcnt <= '0;
            else if (ce) vcnt <= vcnt + CW'(in_vld) - CW'(out_vld);
         end

         always_ff @(posedge clk) rst_d <= rst;

         AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !ce |=> ($stable(p_re) && $stable(p_im) && $stable(out_vld))); // R7

         AST_VLD_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
            (vcnt <= CW'(LAT)) && (!out_vld || vcnt != '0)); // R4

         always_ff @(posedge clk) begin
            if (rst_d)
               AST_RST_CLEAR: assert (p_re == '0 && p_im == '0 && !out_vld); // R8
         end
      end
   endgenerate

endmodule

// File: tb/cmul_refpipe.sv
// Behavioural reference: integer arithmetic delayed through a queue.
module cmul_refpipe #(
   parameter int LAT  = 1,
   parameter bit CONJ = 1'b0,
   parameter int OW   = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  int   ar,
   input  int   ai,
   input  int   br,
   input  int   bi,
   input  logic vld,
   output int   e_re,
   output int   e_im,
   output logic e_vld
);

   int q_re[$];
   int q_im[$];
   bit q_v[$];
   int now_re, now_im;
   int h_re, h_im;
   logic h_v;

   function automatic int wrap(int v);
      int s;
      s = 32 - OW;
      return (v <<< s) >>> s;
   endfunction

   always_comb begin
      if (CONJ) begin
         now_re = wrap(ar*br + ai*bi);
         now_im = wrap(ai*br - ar*bi);
      end else begin
         now_re = wrap(ar*br - ai*bi);
         now_im = wrap(ar*bi + ai*br);
      end
   end

   initial begin
      h_re = 0; h_im = 0; h_v = 1'b0;
      for (int i = 0; i < LAT; i++) begin
         q_re.push_back(0); q_im.push_back(0); q_v.push_back(1'b0);
      end
   end

   always @(posedge clk) begin
      if (LAT > 0) begin
         if (rst) begin
            q_re.delete(); q_im.delete(); q_v.delete();
            for (int i = 0; i < LAT; i++) begin
               q_re.push_back(0); q_im.push_back(0); q_v.push_back(1'b0);
            end
         end else if (ce) begin
            q_re.push_back(now_re); q_im.push_back(now_im); q_v.push_back(vld);
            void'(q_re.pop_front()); void'(q_im.pop_front()); void'(q_v.pop_front());
         end
         h_re = q_re[0]; h_im = q_im[0]; h_v = q_v[0];
      end
   end

   assign e_re  = (LAT == 0) ? now_re : h_re;
   assign e_im  = (LAT == 0) ? now_im : h_im;
   assign e_vld = (LAT == 0) ? vld    : h_v;

endmodule

// File: tb/cplx_mult_pipe_tb.sv
module cplx_mult_pipe_tb;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ce  = 1'b1;
   logic signed [3:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
   logic in_vld = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   bit started = 1'b0;
   string phase = "init";

   always #10 clk = ~clk;   // 50 MHz

   logic signed [8:0]  d0_re, d0_im, d1_re, d1_im;
   logic signed [5:0]  d2_re, d2_im;
   logic signed [11:0] d3_re, d3_im;
   logic d0_v, d1_v, d2_v, d3_v;

   cplx_mult_pipe #(.OUT_W(9), .CONJ_B(1'b0), .DEPTH_IN(1), .DEPTH_PROD(0), .DEPTH_ADD(1), .DEPTH_OUT(1)) u_dut (
      .clk(clk), .rst(rst), .ce(ce), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .in_vld(in_vld), .p_re(d0_re), .p_im(d0_im), .out_vld(d0_v));
   cplx_mult_pipe #(.OUT_W(9), .CONJ_B(1'b1), .DEPTH_IN(0), .DEPTH_PROD(2), .DEPTH_ADD(1), .DEPTH_OUT(0)) u_conj (
      .clk(clk), .rst(rst), .ce(ce), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .in_vld(in_vld), .p_re(d1_re), .p_im(d1_im), .out_vld(d1_v));
   cplx_mult_pipe #(.OUT_W(6), .CONJ_B(1'b0), .DEPTH_IN(0), .DEPTH_PROD(0), .DEPTH_ADD(0), .DEPTH_OUT(0)) u_comb (
      .clk(clk), .rst(rst), .ce(ce), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .in_vld(in_vld), .p_re(d2_re), .p_im(d2_im), .out_vld(d2_v));
   cplx_mult_pipe #(.OUT_W(12), .CONJ_B(1'b1), .DEPTH_IN(2), .DEPTH_PROD(1), .DEPTH_ADD(0), .DEPTH_OUT(1)) u_wide (
      .clk(clk), .rst(rst), .ce(ce), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .in_vld(in_vld), .p_re(d3_re), .p_im(d3_im), .out_vld(d3_v));

   int e0_re, e0_im, e1_re, e1_im, e2_re, e2_im, e3_re, e3_im;
   logic e0_v, e1_v, e2_v, e3_v;

   cmul_refpipe #(.LAT(3), .CONJ(1'b0), .OW(9)) m0 (.clk(clk), .rst(rst), .ce(ce),
      .ar(int'(a_re)), .ai(int'(a_im)), .br(int'(b_re)), .bi(int'(b_im)), .vld(in_vld),
      .e_re(e0_re), .e_im(e0_im), .e_vld(e0_v));
   cmul_refpipe #(.LAT(3), .CONJ(1'b1), .OW(9)) m1 (.clk(clk), .rst(rst), .ce(ce),
      .ar(int'(a_re)), .ai(int'(a_im)), .br(int'(b_re)), .bi(int'(b_im)), .vld(in_vld),
      .e_re(e1_re), .e_im(e1_im), .e_vld(e1_v));
   cmul_refpipe #(.LAT(0), .CONJ(1'b0), .OW(6)) m2 (.clk(clk), .rst(rst), .ce(ce),
      .ar(int'(a_re)), .ai(int'(a_im)), .br(int'(b_re)), .bi(int'(b_im)), .vld(in_vld),
      .e_re(e2_re), .e_im(e2_im), .e_vld(e2_v));
   cmul_refpipe #(.LAT(4), .CONJ(1'b1), .OW(12)) m3 (.clk(clk), .rst(rst), .ce(ce),
      .ar(int'(a_re)), .ai(int'(a_im)), .br(int'(b_re)), .bi(int'(b_im)), .vld(in_vld),
      .e_re(e3_re), .e_im(e3_im), .e_vld(e3_v));

   task automatic chk(string req, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s (%s) got=%0d exp=%0d", req, what, phase, got, exp);
      end
   endtask

   task automatic drive(int ar, int ai, int br, int bi, bit v);
      @(posedge clk); #1;
      a_re = 4'(ar); a_im = 4'(ai); b_re = 4'(br); b_im = 4'(bi); in_vld = v;
   endtask

   function automatic int rnd4();
      return int'($urandom_range(15)) - 8;
   endfunction

   // cycle-by-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         chk("R1/R3", "u_dut re", int'(d0_re), e0_re);
         chk("R1/R3", "u_dut im", int'(d0_im), e0_im);
         chk("R4",    "u_dut vld", int'(d0_v), int'(e0_v));
         chk("R2/R3", "u_conj re", int'(d1_re), e1_re);
         chk("R2/R3", "u_conj im", int'(d1_im), e1_im);
         chk("R4",    "u_conj vld", int'(d1_v), int'(e1_v));
         chk("R6/R3", "u_comb re", int'(d2_re), e2_re);
         chk("R6/R3", "u_comb im", int'(d2_im), e2_im);
         chk("R4",    "u_comb vld", int'(d2_v), int'(e2_v));
         chk("R6/R3", "u_wide re", int'(d3_re), e3_re);
         chk("R6/R3", "u_wide im", int'(d3_im), e3_im);
         chk("R4",    "u_wide vld", int'(d3_v), int'(e3_v));
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R3 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic signed [8:0]  h0_re, h0_im;
      logic signed [11:0] h3_re;
      logic h0_v;

      // ---- reset with busy inputs (R8) ----
      phase = "reset";
      drive(3, -2, 5, 7, 1'b1);
      started = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8", "u_dut re in reset", int'(d0_re), 0);
      chk("R8", "u_dut im in reset", int'(d0_im), 0);
      chk("R8", "u_dut vld in reset", int'(d0_v), 0);
      chk("R8", "u_wide re in reset", int'(d3_re), 0);
      chk("R8", "u_wide vld in reset", int'(d3_v), 0);
      @(posedge clk); #1; rst = 1'b0;

      // ---- directed corners (R5) ----
      phase = "R5 corners";
      drive(2, 4, 3, 5, 1'b1);
      drive(7, 7, 7, 7, 1'b1);
      drive(-8, -8, -8, -8, 1'b0);
      drive(7, 7, -8, -8, 1'b1);
      drive(7, 7, -7, -7, 1'b1);
      drive(-8, -8, -7, -7, 1'b0);

      drive(7, 7, 7, 7, 1'b1);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R5", "all max plain re", int'(d0_re), 0);
      chk("R5", "all max plain im", int'(d0_im), 98);
      chk("R5", "all max conj re", int'(d1_re), 98);
      chk("R5", "all max conj im", int'(d1_im), 0);
      chk("R6", "all max wrap im", int'(d2_im), -30);
      chk("R6", "all max sext re", int'(d3_re), 98);

      drive(-8, -8, -8, -8, 1'b1);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R5", "all min plain im", int'(d0_im), 128);
      chk("R5", "all min conj re", int'(d1_re), 128);
      chk("R5", "all min conj im", int'(d1_im), 0);
      chk("R6", "all min wrap im", int'(d2_im), 0);
      chk("R6", "all min sext re", int'(d3_re), 128);

      // ---- clock-enable gating (R7) ----
      phase = "R7 ce";
      for (int i = 0; i < 300; i++) begin
         drive(rnd4(), rnd4(), rnd4(), rnd4(), 1'($urandom_range(1)));
         ce = 1'($urandom_range(1));
      end
      drive(5, -3, 2, 6, 1'b1);
      ce = 1'b1;
      repeat (6) @(posedge clk);
      @(negedge clk);
      h0_re = d0_re; h0_im = d0_im; h0_v = d0_v; h3_re = d3_re;
      @(posedge clk); #1; ce = 1'b0;
      for (int i = 0; i < 5; i++) drive(rnd4(), rnd4(), rnd4(), rnd4(), 1'b0);
      @(negedge clk);
      chk("R7", "u_dut re held", int'(d0_re), int'(h0_re));
      chk("R7", "u_dut im held", int'(d0_im), int'(h0_im));
      chk("R7", "u_dut vld held", int'(d0_v), int'(h0_v));
      chk("R7", "u_wide re held", int'(d3_re), int'(h3_re));
      @(posedge clk); #1; ce = 1'b1;

      // ---- exhaustive symmetric sweep (R1, R2, R3, R4, R6) ----
      phase = "sweep";
      for (int i = -7; i <= 7; i++)
         for (int j = -7; j <= 7; j++)
            for (int k = -7; k <= 7; k++)
               for (int l = -7; l <= 7; l++)
                  drive(i, k, j, l, 1'($urandom_range(1)));

      phase = "drain";
      drive(0, 0, 0, 0, 1'b0);
      repeat (8) @(posedge clk);
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule